// File: doc/BRIEF.md
# Slew Rate Calibration Sequencer

This block runs the high-speed transmit slew-rate calibration of one USB 2.0 port without software help. After a start pulse it powers the port's calibration ring oscillator and lets it settle. It then uses a small register-bus master to switch on the free-running measurement clock, program a frequency meter for a 1024-cycle window on the selected port's channel, and enable the meter. It polls the meter's valid flag a bounded number of times and reads the measured count even if the flag never comes.

Once the count is in hand, the sequencer turns the meter off and stops the free-running clock. It then works out a 3-bit slew code as round((1024 × 26 × 28 / count) / 1000). A shared restoring divider makes two passes: the first divides, and the second applies the rounding. A zero count yields the fallback code 4. The code is presented with a one-cycle write strobe, after which the oscillator is switched off and done pulses.

Top module: `slew_cal_seq`

## Requirements
- R1: After start, the first actions come in this order: `osc_en` rises; a write to the monitor register sets bit 8 (free-run clock on); a write to the control register leaves bit 24 clear; a write to the control register sets bit 24 (meter on); then reads of the monitor register begin.
- R2: At least `SETTLE_CYC` clock cycles pass between `osc_en` rising and the first bus request.
- R3: Every control-register write carries the window length 1024 in bits 23:0 and the port index in bits 27:26. Only the meter-enable write sets bit 24.
- R4: The monitor register is read repeatedly, and its bit 0 is the valid flag. Reads are at least `POLL_GAP` cycles apart. Polling stops at the first read with the flag set, or after `MAX_POLLS` reads. The value register is read in either case, and its value is used.
- R5: After the count is read, the shutdown comes in this order: a control write with bit 24 clear; a monitor write with bit 8 clear; a one-cycle `slew_wr` strobe; `osc_en` falling.
- R6: For a nonzero count c, `slew_code` at the strobe is the low 3 bits of (q + 500) / 1000, where q = 745472 / c and both divisions truncate.
- R7: A count of zero gives `slew_code` = 4 at the strobe.
- R8: `done` is high for exactly one cycle, in the first cycle with `osc_en` low after the strobe. A start received while a calibration is running has no effect.
- R9: Under reset, `osc_en`, `bus_req`, `slew_wr` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration (accepted only when idle) |
| port_idx | input | 2 | Port under calibration; also selects the meter channel |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| bus_rdata | input | 32 | Read data |
| osc_en | output | 1 | Calibration ring-oscillator enable |
| slew_code | output | 3 | Computed slew-rate code |
| slew_wr | output | 1 | One-cycle strobe that writes `slew_code` into the port's slew field |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `SETTLE_CYC` = 4, `POLL_GAP` = 8 and `MAX_POLLS` = 3, instead of the defaults of 200, 2000 and 20 (1 µs, 10 µs and 200 µs at 200 MHz). These short windows make both the early-valid path and the full timeout path quick to reach in every vector. The bench can then sweep counts whose rounded results sit just above and just below a half step (1490 and 1491), and counts that exceed 7 and wrap in the 3-bit field. A bus-slave model decides after how many polls the flag rises and logs every transaction, so the bench can check the order of power-up and power-down and the layout of the control fields.

// File: rtl/slew_cal_seq.sv
module slew_cal_seq #(
  parameter int ADDR_W       = 8,
  parameter int SETTLE_CYC   = 200,
  parameter int POLL_GAP     = 2000,
  parameter int MAX_POLLS    = 20,
  parameter int WIN_CYC      = 1024,
  parameter int REF_MHZ      = 26,
  parameter int COEF         = 28,
  parameter int SCALE        = 1000,
  parameter int DEFAULT_CODE = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] VAL_ADDR  = 'h0C,
  parameter logic [ADDR_W-1:0] MON_ADDR  = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        port_idx,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              osc_en,
  output logic [2:0]        slew_code,
  output logic              slew_wr,
  output logic              done
);
  localparam int TMAX = (SETTLE_CYC > POLL_GAP) ? SETTLE_CYC : POLL_GAP;
  localparam int TW = $clog2(TMAX + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [31:0] NUMER = 32'(WIN_CYC * REF_MHZ * COEF);

  typedef enum logic [3:0] {
    S_IDLE, S_SETTLE, S_FRCK_ON, S_PROG, S_MEN, S_POLL, S_GAP, S_RDVAL,
    S_MOFF, S_FRCK_OFF, S_DIV1, S_DIV2, S_WRCODE, S_DONE
  } st_t;

  st_t st;
  logic [TW-1:0] timer;
  logic [PW-1:0] polls;
  logic [1:0]    chan;
  logic [31:0]   cnt, rem, quo, dsr;
  logic [4:0]    step;
  logic [2:0]    code;

  logic [32:0] r_sh, diff;
  logic        fits;
  logic [31:0] rem_n, quo_n;
  logic [31:0] ctrl_base;

  assign r_sh  = {rem, quo[31]};
  assign diff  = r_sh - {1'b0, dsr};
  assign fits  = r_sh >= {1'b0, dsr};
  assign rem_n = fits ? diff[31:0] : r_sh[31:0];
  assign quo_n = {quo[30:0], fits};

  assign ctrl_base = {4'b0, chan, 2'b0, 24'(WIN_CYC)};

  assign osc_en    = (st != S_IDLE) && (st != S_DONE);
  assign done      = (st == S_DONE);
  assign slew_wr   = (st == S_WRCODE);
  assign slew_code = code;

  always_comb begin
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    case (st)
      S_FRCK_ON:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = MON_ADDR;  bus_wdata = 32'h100; end
      S_PROG:     begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = CTRL_ADDR; bus_wdata = ctrl_base; end
      S_MEN:      begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = CTRL_ADDR; bus_wdata = ctrl_base | 32'h0100_0000; end
      S_POLL:     begin bus_req = 1'b1; bus_addr = MON_ADDR; end
      S_RDVAL:    begin bus_req = 1'b1; bus_addr = VAL_ADDR; end
      S_MOFF:     begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = CTRL_ADDR; bus_wdata = ctrl_base; end
      S_FRCK_OFF: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = MON_ADDR;  bus_wdata = 32'h0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; timer <= '0; polls <= '0; chan <= '0; cnt <= '0;
      rem <= '0; quo <= '0; dsr <= '0; step <= '0; code <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          chan <= port_idx; timer <= '0; polls <= '0; st <= S_SETTLE;
        end
        S_SETTLE: if (timer == TW'(SETTLE_CYC - 1)) st <= S_FRCK_ON;
                  else timer <= timer + 1'b1;
        S_FRCK_ON: if (bus_ack) st <= S_PROG;
        S_PROG:    if (bus_ack) st <= S_MEN;
        S_MEN:     if (bus_ack) st <= S_POLL;
        S_POLL: if (bus_ack) begin
          if (bus_rdata[0] || polls == PW'(MAX_POLLS - 1)) st <= S_RDVAL;
          else begin
            polls <= polls + 1'b1; timer <= '0; st <= S_GAP;
          end
        end
        S_GAP: if (timer == TW'(POLL_GAP - 1)) st <= S_POLL;
               else timer <= timer + 1'b1;
        S_RDVAL: if (bus_ack) begin cnt <= bus_rdata; st <= S_MOFF; end
        S_MOFF:  if (bus_ack) st <= S_FRCK_OFF;
        S_FRCK_OFF: if (bus_ack) begin
          if (cnt == '0) begin
            code <= 3'(DEFAULT_CODE); st <= S_WRCODE;
          end else begin
            rem <= '0; quo <= NUMER; dsr <= cnt; step <= '0; st <= S_DIV1;
          end
        end
        S_DIV1: begin
          rem <= rem_n; quo <= quo_n; step <= step + 1'b1;
          if (step == 5'd31) begin
            rem <= '0; quo <= quo_n + 32'(SCALE / 2); dsr <= 32'(SCALE);
            st <= S_DIV2;
          end
        end
        S_DIV2: begin
          rem <= rem_n; quo <= quo_n; step <= step + 1'b1;
          if (step == 5'd31) begin code <= quo_n[2:0]; st <= S_WRCODE; end
        end
        S_WRCODE: st <= S_DONE;
        S_DONE:   st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_osc_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !osc_en);
  assert_bus_with_osc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> osc_en);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));
  assert_strobe_before_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slew_wr |-> osc_en && !bus_req);
  assert_strobe_then_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slew_wr |=> !osc_en && done);
endmodule

// File: tb/test_slew_cal_seq.sv
module test_slew_cal_seq;
  localparam int SET = 4, GAP = 8, MAXP = 3;
  localparam int NV = 13;
  localparam int unsigned V_CNT[NV]  = '{1, 1000, 186, 100, 200, 250, 500, 1500, 134, 93, 1491, 1490, 0};
  localparam int          V_EXP[NV]  = '{1, 1, 4, 7, 4, 3, 1, 0, 6, 0, 0, 1, 4};
  localparam int          V_PORT[NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 0, 1, 2, 3, 0};
  localparam int          V_VA[NV]   = '{0, 1, 0, 2, 0, 0, 0, 0, 1, 0, 0, 0, 2};

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] port_idx = 0;
  logic bus_req, bus_we, bus_ack = 0;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = 0;
  logic osc_en, slew_wr, done;
  logic [2:0] slew_code;

  always #2.5 clk = ~clk;

  slew_cal_seq #(.SETTLE_CYC(SET), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) i_slew_cal_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .port_idx(port_idx),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .osc_en(osc_en), .slew_code(slew_code),
    .slew_wr(slew_wr), .done(done));

  int checks = 0, failures = 0, wd = 0;
  int unsigned count_val;
  int valid_at, poll_n, stage, dones, rises, strobes, cyc, t_rise, t_req, t_poll, min_gap;
  bit order_err, done_wide, done_prev, osc_prev, first_req;
  logic [31:0] c_prog, c_en, c_off, m_on, m_off;
  logic [2:0] got_code;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got %0d exp %0d", tag, act, exp);
    end
  endtask

  function automatic void ev(input int e);
    if (e == stage + 1 || (e == 5 && stage == 5)) stage = e;
    else order_err = 1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (bus_ack) bus_ack = 0;
    else if (bus_req) begin
      bus_ack = 1;
      if (!first_req) begin first_req = 1; t_req = cyc; end
      if (bus_we) begin
        if (bus_addr == 8'h10) begin
          if (bus_wdata[8]) begin m_on = bus_wdata; ev(2); end
          else begin m_off = bus_wdata; ev(8); end
        end else if (bus_addr == 8'h00) begin
          if (bus_wdata[24]) begin c_en = bus_wdata; ev(4); end
          else if (stage == 2) begin c_prog = bus_wdata; ev(3); end
          else begin c_off = bus_wdata; ev(7); end
        end else order_err = 1;
      end else begin
        if (bus_addr == 8'h10) begin
          if (poll_n > 0 && cyc - t_poll < min_gap) min_gap = cyc - t_poll;
          t_poll = cyc;
          bus_rdata = (poll_n >= valid_at) ? 32'h1 : 32'h0;
          poll_n++; ev(5);
        end else if (bus_addr == 8'h0C) begin
          bus_rdata = count_val; ev(6);
        end else order_err = 1;
      end
    end
    if (slew_wr) begin strobes++; got_code = slew_code; ev(9); end
    if (!osc_prev && osc_en) begin rises++; t_rise = cyc; ev(1); end
    if (osc_prev && !osc_en) ev(10);
    if (done) begin dones++; if (osc_en) order_err = 1; end
    if (done && done_prev) done_wide = 1;
    done_prev = done;
    osc_prev = osc_en;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input int unsigned cnt, input int va, input int port, input bit poke);
    int w;
    count_val = cnt; valid_at = va; poll_n = 0; stage = 0; order_err = 0;
    dones = 0; rises = 0; strobes = 0; first_req = 0; min_gap = 1 << 20; done_wide = 0;
    got_code = 3'bxxx;
    @(negedge clk); start = 1; port_idx = 2'(port);
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1; port_idx = 2'(port ^ 1);
      @(negedge clk); start = 0;
    end
    w = 0;
    while (dones == 0 && w < 5000) begin @(negedge clk); w++; end
    if (w >= 5000) chk(0, "watchdog run R8", 0, 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic verify(input int exp_code, input int port, input int exp_polls);
    logic [31:0] base;
    base = {4'b0, 2'(port), 2'b0, 24'd1024};
    chk(!order_err && stage == 10, "R1/R5 order", stage, 10);
    chk(t_req - t_rise >= SET, "R2 settle", t_req - t_rise, SET);
    chk(c_prog == base && c_off == base, "R3 ctrl fields", int'(c_prog), int'(base));
    chk(c_en == (base | 32'h0100_0000), "R3 enable word", int'(c_en), int'(base | 32'h0100_0000));
    chk(m_on == 32'h100 && m_off[8] == 1'b0, "R1 free-run clock", int'(m_on), 256);
    chk(poll_n == exp_polls, "R4 poll count", poll_n, exp_polls);
    if (poll_n > 1) chk(min_gap >= GAP, "R4 poll gap", min_gap, GAP);
    chk(strobes == 1 && got_code == 3'(exp_code), "R6/R7 code", int'(got_code), exp_code);
    chk(dones == 1 && !done_wide, "R8 done pulse", dones, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!osc_en && !bus_req && !slew_wr && !done, "R9 reset outputs",
        int'({osc_en, bus_req, slew_wr, done}), 0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      run(V_CNT[i], V_VA[i], V_PORT[i], 0);
      verify(V_EXP[i], V_PORT[i], (V_VA[i] < MAXP) ? V_VA[i] + 1 : MAXP);
    end
    // R4: flag never set, count still used after MAX polls
    run(250, 99, 2, 0);
    verify(3, 2, MAXP);
    // R7: zero count after timeout
    run(0, 99, 1, 0);
    verify(4, 1, MAXP);
    // R8: start while busy is ignored (one oscillator rise, original channel)
    run(1490, 1, 3, 1);
    verify(1, 3, 2);
    chk(rises == 1, "R8 busy start ignored", rises, 1);
    chk(!osc_en && !bus_req, "R8 idle after run", int'({osc_en, bus_req}), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule